// File: doc/BRIEF.md
# Integer Execute Stage

This block is the combinational execute stage of a 64-bit integer core. Each evaluation takes one 32-bit instruction word, the two source operand values already read from the register file, and the address of that instruction. It classifies the word by its opcode and function fields. It forms the immediate that belongs to the instruction's format and computes the result. It also reports which destination register the result targets and whether that write should happen.

The supported set is:

- register-register: add, subtract, xor, or, and, and the three register shifts;
- immediate: add, xor, or, and, and the three immediate shifts;
- upper-immediate: load upper immediate, and add upper immediate to the instruction address.

Every other encoding is flagged as illegal and produces no write. The block has no state and no clock. The surrounding pipeline registers its inputs and captures its outputs within the same cycle.

Top module: `ex_unit`

## Requirements
- R1: With opcode 0110011 and funct3 000, funct7 0000000 gives rs1+rs2 and funct7 0100000 gives rs1-rs2, both modulo 2^64.
- R2: With opcode 0110011 and funct7 0000000, funct3 100, 110 and 111 give the bitwise xor, or and and of rs1 and rs2.
- R3: With opcode 0110011, funct3 001 with funct7 0000000 shifts rs1 left, and funct3 101 shifts rs1 right, logically when funct7 is 0000000 and arithmetically when it is 0100000. In all three cases the shift amount is rs2[5:0].
- R4: With opcode 0010011, funct3 000, 100, 110 and 111 combine rs1 with the immediate instr[31:20] sign-extended to 64 bits, by add, xor, or and and respectively. An immediate with bit 11 set therefore subtracts on add.
- R5: With opcode 0010011 and funct3 001 or 101, the shift amount is instr[25:20]. instr[31:26] must be 000000 for the left shift and for the logical right shift, and 010000 for the arithmetic right shift. Any other value is illegal.
- R6: Arithmetic right shifts fill the vacated high bits with rs1[63]. Logical right shifts and left shifts fill with zeros.
- R7: Opcode 0110111 returns instr[31:12] placed at bits 31:12, with bits 11:0 zero and bits 63:32 copies of instr[31].
- R8: Opcode 0010111 returns the PC plus the R7 value, modulo 2^64.
- R9: rd_o always equals instr[11:7]. reg_write_o is high exactly when the instruction is legal and rd_o is not 0, so a write aimed at register 0 is suppressed.
- R10: Any opcode, funct3, funct7 or funct6 combination outside R1 to R8 raises illegal_o, forces result_o to 0 and keeps reg_write_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | First source operand value |
| rs2_val_i | input | 64 | Second source operand value |
| pc_i | input | 64 | Address of the instruction |
| result_o | output | 64 | Computed result, 0 when illegal |
| rd_o | output | 5 | Destination register index |
| reg_write_o | output | 1 | Destination write enable |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
Every output is a pure function of the present inputs, so all results are due zero cycles after a stimulus. No register sits between an input and an output. The bench applies each vector away from the clock edge and waits a short delay within the same cycle before it compares. It never carries an expectation across an edge. Because the assertions are evaluated combinationally, they check each settled input/output set rather than sampled history.

// File: rtl/ex_unit_pkg.sv
package ex_unit_pkg;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [5:0] F6_BASE = 6'b000000;
  localparam logic [5:0] F6_ALT  = 6'b010000;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_XOR, ALU_OR, ALU_AND, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {SRC_A_RS1, SRC_A_PC, SRC_A_ZERO} src_a_e;
  typedef enum logic [1:0] {SRC_B_RS2, SRC_B_IMM_I, SRC_B_IMM_U} src_b_e;

  typedef struct packed {
    alu_op_e op;
    src_a_e  a_sel;
    src_b_e  b_sel;
    logic    legal;
  } dec_t;
endpackage

// File: rtl/ex_decode.sv
module ex_decode
  import ex_unit_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [6:0] opc, f7;
  logic [5:0] f6;
  logic [2:0] f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];
  assign f6  = instr_i[31:26];

  always_comb begin
    dec_o = '{op: ALU_ADD, a_sel: SRC_A_RS1, b_sel: SRC_B_RS2, legal: 1'b0};
    unique case (opc)
      OPC_REG: begin
        dec_o.b_sel = SRC_B_RS2;
        unique case (f3)
          3'b000: begin
            if (f7 == F7_BASE)     begin dec_o.op = ALU_ADD; dec_o.legal = 1'b1; end
            else if (f7 == F7_ALT) begin dec_o.op = ALU_SUB; dec_o.legal = 1'b1; end
          end
          3'b001: if (f7 == F7_BASE) begin dec_o.op = ALU_SLL; dec_o.legal = 1'b1; end
          3'b100: if (f7 == F7_BASE) begin dec_o.op = ALU_XOR; dec_o.legal = 1'b1; end
          3'b101: begin
            if (f7 == F7_BASE)     begin dec_o.op = ALU_SRL; dec_o.legal = 1'b1; end
            else if (f7 == F7_ALT) begin dec_o.op = ALU_SRA; dec_o.legal = 1'b1; end
          end
          3'b110: if (f7 == F7_BASE) begin dec_o.op = ALU_OR;  dec_o.legal = 1'b1; end
          3'b111: if (f7 == F7_BASE) begin dec_o.op = ALU_AND; dec_o.legal = 1'b1; end
          default: ;
        endcase
      end
      OPC_IMM: begin
        dec_o.b_sel = SRC_B_IMM_I;
        unique case (f3)
          3'b000: begin dec_o.op = ALU_ADD; dec_o.legal = 1'b1; end
          3'b100: begin dec_o.op = ALU_XOR; dec_o.legal = 1'b1; end
          3'b110: begin dec_o.op = ALU_OR;  dec_o.legal = 1'b1; end
          3'b111: begin dec_o.op = ALU_AND; dec_o.legal = 1'b1; end
          // upper immediate bits act as a sub-opcode for shifts
          3'b001: if (f6 == F6_BASE) begin dec_o.op = ALU_SLL; dec_o.legal = 1'b1; end
          3'b101: begin
            if (f6 == F6_BASE)     begin dec_o.op = ALU_SRL; dec_o.legal = 1'b1; end
            else if (f6 == F6_ALT) begin dec_o.op = ALU_SRA; dec_o.legal = 1'b1; end
          end
          default: ;
        endcase
      end
      OPC_LUI: begin
        dec_o.a_sel = SRC_A_ZERO;
        dec_o.b_sel = SRC_B_IMM_U;
        dec_o.legal = 1'b1;
      end
      OPC_AUIPC: begin
        dec_o.a_sel = SRC_A_PC;
        dec_o.b_sel = SRC_B_IMM_U;
        dec_o.legal = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ex_imm.sv
module ex_imm #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr_i,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_u_o
);
  localparam int IW = 12;

  assign imm_i_o = {{(XLEN-IW){instr_i[31]}}, instr_i[31:20]};

  generate
    if (XLEN > 32) begin : g_wide
      assign imm_u_o = {{(XLEN-32){instr_i[31]}}, instr_i[31:12], {IW{1'b0}}};
    end else begin : g_narrow
      assign imm_u_o = {instr_i[31:12], {IW{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_SLL: y_o = a_i << shamt;
      ALU_SRL: y_o = a_i >> shamt;
      ALU_SRA: y_o = $unsigned($signed(a_i) >>> shamt);
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/ex_unit.sv
module ex_unit
  import ex_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            reg_write_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic [XLEN-1:0] imm_i, imm_u, op_a, op_b, alu_y;

  ex_decode u_decode (.instr_i(instr_i), .dec_o(dec));

  ex_imm #(.XLEN(XLEN)) u_imm (.instr_i(instr_i), .imm_i_o(imm_i), .imm_u_o(imm_u));

  always_comb begin
    unique case (dec.a_sel)
      SRC_A_PC:   op_a = pc_i;
      SRC_A_ZERO: op_a = '0;
      default:    op_a = rs1_val_i;
    endcase
    unique case (dec.b_sel)
      SRC_B_IMM_I: op_b = imm_i;
      SRC_B_IMM_U: op_b = imm_u;
      default:     op_b = rs2_val_i;
    endcase
  end

  ex_alu #(.XLEN(XLEN)) u_alu (.op_i(dec.op), .a_i(op_a), .b_i(op_b), .y_o(alu_y));

  assign rd_o        = instr_i[11:7];
  assign illegal_o   = ~dec.legal;
  assign result_o    = dec.legal ? alu_y : '0;
  assign reg_write_o = dec.legal && (rd_o != 5'd0);
endmodule

// File: rtl/ex_unit_chk.sv
module ex_unit_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] rs2_val_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      rd_o,
  input logic            reg_write_o,
  input logic            illegal_o
);
  logic [XLEN-1:0] auipc_off;
  logic            is_sub, is_srai, is_lui, is_auipc;

  assign auipc_off = result_o - pc_i;
  assign is_sub    = instr_i[6:0] == 7'b0110011 && instr_i[14:12] == 3'b000 &&
                     instr_i[31:25] == 7'b0100000;
  assign is_srai   = instr_i[6:0] == 7'b0010011 && instr_i[14:12] == 3'b101 &&
                     instr_i[31:26] == 6'b010000;
  assign is_lui    = instr_i[6:0] == 7'b0110111;
  assign is_auipc  = instr_i[6:0] == 7'b0010111;

  always_comb begin
    assert_no_dead_write_R9: assert (!reg_write_o || (rd_o != 5'd0 && !illegal_o))
      else $error("write enabled for rd 0 or illegal instruction");
    assert_illegal_quiet_R10: assert (!illegal_o || (result_o == '0 && !reg_write_o))
      else $error("illegal instruction produced a result or write");
    assert_sub_inverse_R1: assert (!is_sub || (result_o + rs2_val_i == rs1_val_i))
      else $error("subtract result inconsistent");
    assert_sra_fill_R6: assert (!(is_srai && rs1_val_i[XLEN-1]) || result_o[XLEN-1])
      else $error("arithmetic shift lost sign");
    assert_lui_shape_R7: assert (!is_lui || (result_o[11:0] == 12'd0 &&
                                 (&result_o[XLEN-1:31] || ~|result_o[XLEN-1:31])))
      else $error("upper immediate badly formed");
    assert_auipc_align_R8: assert (!is_auipc || auipc_off[11:0] == 12'd0)
      else $error("pc-relative offset has low bits set");
  end
endmodule

bind ex_unit ex_unit_chk #(.XLEN(XLEN)) u_chk (
  .instr_i(instr_i), .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .pc_i(pc_i),
  .result_o(result_o), .rd_o(rd_o), .reg_write_o(reg_write_o), .illegal_o(illegal_o)
);

// File: tb/ex_unit_bench.sv
module ex_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic [63:0] rs1, rs2, pc;
  logic [63:0] result;
  logic [4:0]  rd;
  logic        wr, ill;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ex_unit u_ex_unit (
    .instr_i(instr), .rs1_val_i(rs1), .rs2_val_i(rs2), .pc_i(pc),
    .result_o(result), .rd_o(rd), .reg_write_o(wr), .illegal_o(ill)
  );

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                        input logic [4:0] d, s1, s2);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3,
                                        input logic [4:0] d, s1);
    return {imm, s1, f3, d, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] imm, input bit pcrel,
                                        input logic [4:0] d);
    return {imm, d, pcrel ? 7'b0010111 : 7'b0110111};
  endfunction

  // independent reference of the requirement text
  function automatic void model(input logic [31:0] w, input logic [63:0] a, b, p,
                                output logic [63:0] y, output bit ok);
    logic [63:0] si = {{52{w[31]}}, w[31:20]};
    logic [63:0] su = {{32{w[31]}}, w[31:12], 12'h000};
    int sh_r = int'(b[5:0]);
    int sh_i = int'(w[25:20]);
    y = 64'd0; ok = 1'b0;
    if (w[6:0] == 7'b0110111) begin y = su; ok = 1'b1; end
    else if (w[6:0] == 7'b0010111) begin y = p + su; ok = 1'b1; end
    else if (w[6:0] == 7'b0110011) begin
      ok = 1'b1;
      case ({w[31:25], w[14:12]})
        {7'h00, 3'd0}: y = a + b;
        {7'h20, 3'd0}: y = a - b;
        {7'h00, 3'd4}: y = a ^ b;
        {7'h00, 3'd6}: y = a | b;
        {7'h00, 3'd7}: y = a & b;
        {7'h00, 3'd1}: y = a << sh_r;
        {7'h00, 3'd5}: y = a >> sh_r;
        {7'h20, 3'd5}: for (int k = 0; k < 64; k++) y[k] = (k + sh_r < 64) ? a[k+sh_r] : a[63];
        default: ok = 1'b0;
      endcase
    end else if (w[6:0] == 7'b0010011) begin
      ok = 1'b1;
      case (w[14:12])
        3'd0: y = a + si;
        3'd4: y = a ^ si;
        3'd6: y = a | si;
        3'd7: y = a & si;
        3'd1: if (w[31:26] == 6'd0) y = a << sh_i; else ok = 1'b0;
        3'd5: if (w[31:26] == 6'd0) y = a >> sh_i;
              else if (w[31:26] == 6'b010000)
                for (int k = 0; k < 64; k++) y[k] = (k + sh_i < 64) ? a[k+sh_i] : a[63];
              else ok = 1'b0;
        default: ok = 1'b0;
      endcase
    end
    if (!ok) y = 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h got=%h exp=%h", tag, instr, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [63:0] a, b, p);
    logic [63:0] ey;
    bit ok;
    @(negedge clk);
    instr = w; rs1 = a; rs2 = b; pc = p;
    #1;
    model(w, a, b, p, ey, ok);
    check(tag, result, ey);
    check("R9 rd", {59'd0, rd}, {59'd0, w[11:7]});
    check("R9 write", {63'd0, wr}, {63'd0, ok && w[11:7] != 5'd0});
    check("R10 illegal", {63'd0, ill}, {63'd0, !ok});
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom_range(0, 5))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] hi;
    void'($urandom(32'h5EED_0042));
    instr = 32'h0000_0013; rs1 = '0; rs2 = '0; pc = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // idle vector: addi x0,x0,0 must not write
    check("R9 idle write", {63'd0, wr}, 64'd0);
    check("R4 idle result", result, 64'd0);

    // directed corners
    apply("R7 lui neg", enc_u(20'hDEADC, 1'b0, 5'd10), 0, 0, 0);
    check("R7 lui value", result, 64'hFFFF_FFFF_DEAD_C000);
    hi = result;
    apply("R4 addi carry", enc_i(12'hEEF, 3'd0, 5'd10, 5'd10), hi, 0, 0);
    check("R4 pair value", result, 64'hFFFF_FFFF_DEAD_BEEF);
    apply("R7 lui pos", enc_u(20'h87654, 1'b0, 5'd10), 0, 0, 0);
    apply("R4 addi minus", enc_i(12'hFCE, 3'd0, 5'd15, 5'd1), 64'd100, 0, 0);
    check("R4 addi -50", result, 64'd50);
    apply("R8 auipc", enc_u(20'hFFFFF, 1'b1, 5'd3), 0, 0, 64'h0000_0000_0000_2000);
    check("R8 auipc value", result, 64'h0000_0000_0000_1000);
    apply("R6 srai 63", enc_i({6'b010000, 6'd63}, 3'd5, 5'd4, 5'd5), 64'h8000_0000_0000_0000, 0, 0);
    check("R6 srai fill", result, '1);
    apply("R6 srli 63", enc_i({6'b000000, 6'd63}, 3'd5, 5'd4, 5'd5), 64'h8000_0000_0000_0000, 0, 0);
    check("R6 srli fill", result, 64'd1);
    apply("R5 bad f6", enc_i({6'b000001, 6'd3}, 3'd5, 5'd4, 5'd5), 64'hFF, 0, 0);
    apply("R5 bad slli", enc_i({6'b010000, 6'd3}, 3'd1, 5'd4, 5'd5), 64'hFF, 0, 0);
    apply("R3 sra by rs2 low bits", enc_r(7'h20, 3'd5, 5'd7, 5'd1, 5'd2), 64'hF000_0000_0000_0000, 64'h44, 0);
    apply("R1 add rd0", enc_r(7'h00, 3'd0, 5'd0, 5'd1, 5'd2), 64'd5, 64'd6, 0);
    apply("R10 slt", enc_r(7'h00, 3'd2, 5'd9, 5'd1, 5'd2), 64'd5, 64'd6, 0);
    apply("R10 bad f7", enc_r(7'h01, 3'd0, 5'd9, 5'd1, 5'd2), 64'd5, 64'd6, 0);
    apply("R10 load opcode", 32'h0080_3703, 64'd5, 64'd6, 0);

    // constrained random over the supported set
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  d = 5'($urandom());
      logic [4:0]  s1 = 5'($urandom());
      logic [4:0]  s2 = 5'($urandom());
      logic [11:0] im = 12'($urandom());
      logic [5:0]  sa = 6'($urandom());
      logic [19:0] iu = 20'($urandom());
      logic [63:0] a = pick64();
      logic [63:0] b = pick64();
      logic [63:0] p = {$urandom(), $urandom()};
      case ($urandom_range(0, 17))
        0:  apply("R1 add",  enc_r(7'h00, 3'd0, d, s1, s2), a, b, p);
        1:  apply("R1 sub",  enc_r(7'h20, 3'd0, d, s1, s2), a, b, p);
        2:  apply("R2 xor",  enc_r(7'h00, 3'd4, d, s1, s2), a, b, p);
        3:  apply("R2 or",   enc_r(7'h00, 3'd6, d, s1, s2), a, b, p);
        4:  apply("R2 and",  enc_r(7'h00, 3'd7, d, s1, s2), a, b, p);
        5:  apply("R3 sll",  enc_r(7'h00, 3'd1, d, s1, s2), a, b, p);
        6:  apply("R3 srl",  enc_r(7'h00, 3'd5, d, s1, s2), a, b, p);
        7:  apply("R3 sra",  enc_r(7'h20, 3'd5, d, s1, s2), a, b, p);
        8:  apply("R4 addi", enc_i(im, 3'd0, d, s1), a, b, p);
        9:  apply("R4 xori", enc_i(im, 3'd4, d, s1), a, b, p);
        10: apply("R4 ori",  enc_i(im, 3'd6, d, s1), a, b, p);
        11: apply("R4 andi", enc_i(im, 3'd7, d, s1), a, b, p);
        12: apply("R5 slli", enc_i({6'd0, sa}, 3'd1, d, s1), a, b, p);
        13: apply("R5 srli", enc_i({6'd0, sa}, 3'd5, d, s1), a, b, p);
        14: apply("R6 srai", enc_i({6'b010000, sa}, 3'd5, d, s1), a, b, p);
        15: apply("R7 lui",  enc_u(iu, 1'b0, d), a, b, p);
        16: apply("R8 auipc", enc_u(iu, 1'b1, d), a, b, p);
        default: apply("R10 random word", $urandom(), a, b, p);
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule